// File: doc/BRIEF.md
# JTAG In-System Programming Mode Controller

This block sits beside a JTAG TAP controller. It reads the 10-bit instruction that the TAP latches at Update-IR and decides which programming mode the device is in. There are four modes: normal user operation, programming with all I/O tri-stated, programming with I/O held to the boundary-scan values and the core frozen, and background programming that runs while user logic keeps going. From the mode and the instruction it drives three I/O control lines, picks the data register the TAP shifts through, and sends program, erase and read strobes to a flash interface.

Flash instructions take effect only inside a programming mode. Program and erase wait until the TAP reaches Run-Test/Idle. Leaving a programming mode is not immediate: the TAP must stay in Run-Test/Idle for a fixed dwell, counted in clock cycles. A reconfiguration request raised during background mode leaves a flag set until background mode is explicitly closed. An unknown opcode falls back to bypass and sets a sticky error flag.

Top module: `isp_mode_ctrl`

## Requirements
- R1: After reset, mode is user (code 0) and every strobe and flag output is low. dr_sel is bypass (code 0).
- R2: Opcode 0x2CC received in user mode enters tri-state programming (mode code 1). io_hiz is high, and io_clamp and core_freeze are low.
- R3: Opcode 0x233 received in user mode enters clamp programming (mode code 2). io_clamp and core_freeze are high and io_hiz is low. A second enable opcode received while already in a programming mode is ignored.
- R4: Opcode 0x201 received in mode 1 or 2 raises exiting, and the I/O controls stay as they are. The mode returns to user only after EXIT_CYC consecutive clock cycles with tap_idle high. Any cycle with tap_idle low restarts the count.
- R5: In user mode, opcodes 0x2F4, 0x2F2, 0x205, 0x203 and 0x210 produce no strobe, and dr_sel stays bypass.
- R6: In a programming or background mode, opcode 0x210 sets dr_sel to 1 (default no-op register) and opcode 0x203 sets dr_sel to 2 (flash address). Any other opcode sets dr_sel to bypass.
- R7: Opcode 0x2F2 yields an erase strobe only if 0x203 has been accepted since the current mode was entered. Otherwise it is dropped.
- R8: Program (0x2F4) and accepted erase wait for tap_idle. Their strobe is high for exactly one cycle: the first cycle after the update in which tap_idle is high.
- R9: Accepted opcode 0x205 pulses read_stb for one cycle, starting in the cycle after the update. addr_inc accompanies a read only when an earlier read has happened since the last 0x203.
- R10: Opcode 0x199 received in user mode enters background mode (code 3) with the I/O controls low. Opcode 0x166 received in background mode returns to user.
- R11: Opcode 0x001, outside modes 1 and 2, gives a one-cycle reconfig_req pulse. In background mode it also sets bg_intr, which only 0x166 clears.
- R12: Opcode 0x00D gives a one-cycle io_cfg_stb pulse only while status_ok is high.
- R13: An opcode outside the supported set selects bypass and sets bad_op. Only reset clears bad_op.
- R14: While exiting is high, no opcode produces a strobe or changes the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_value | input | 10 | Instruction latched by the TAP |
| ir_update | input | 1 | One-cycle pulse at Update-IR |
| tap_idle | input | 1 | TAP is in Run-Test/Idle |
| status_ok | input | 1 | Device status line is high |
| mode | output | 2 | 0 user, 1 tri-state, 2 clamp, 3 background |
| exiting | output | 1 | Timed exit from programming in progress |
| io_hiz | output | 1 | Tri-state all I/O |
| io_clamp | output | 1 | I/O follow boundary-scan cells |
| core_freeze | output | 1 | Freeze core logic |
| dr_sel | output | 2 | 0 bypass, 1 default no-op, 2 flash address |
| prog_stb | output | 1 | Start flash program |
| erase_stb | output | 1 | Start flash erase |
| read_stb | output | 1 | Flash read |
| addr_inc | output | 1 | Advance flash address with this read |
| io_cfg_stb | output | 1 | I/O reconfiguration accepted |
| reconfig_req | output | 1 | Internal reconfiguration request |
| bg_intr | output | 1 | Background mode interrupted by reconfiguration |
| bad_op | output | 1 | Sticky unsupported-opcode flag |

## Verification
The bench builds the block with EXIT_CYC set to 8 instead of a dwell of tens of thousands of cycles. This makes the exact cycle on which the mode returns to user observable, as well as the restart of the count when the TAP briefly leaves Run-Test/Idle. Every other behaviour is independent of this parameter, so the short dwell loses nothing except run time.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int IR_W = 10;

  localparam logic [IR_W-1:0] K_IO_RECONF   = 10'h00D;
  localparam logic [IR_W-1:0] K_REBOOT      = 10'h001;
  localparam logic [IR_W-1:0] K_EN_TRISTATE = 10'h2CC;
  localparam logic [IR_W-1:0] K_EN_HOLD     = 10'h233;
  localparam logic [IR_W-1:0] K_LEAVE       = 10'h201;
  localparam logic [IR_W-1:0] K_PROG        = 10'h2F4;
  localparam logic [IR_W-1:0] K_IDLE_OP     = 10'h210;
  localparam logic [IR_W-1:0] K_ADDR        = 10'h203;
  localparam logic [IR_W-1:0] K_ERASE       = 10'h2F2;
  localparam logic [IR_W-1:0] K_READ        = 10'h205;
  localparam logic [IR_W-1:0] K_BG_ON       = 10'h199;
  localparam logic [IR_W-1:0] K_BG_OFF      = 10'h166;

  typedef enum logic [1:0] {
    MD_USER  = 2'd0,
    MD_HIZ   = 2'd1,
    MD_CLAMP = 2'd2,
    MD_BG    = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    DR_BYP  = 2'd0,
    DR_DFLT = 2'd1,
    DR_ADDR = 2'd2
  } dr_e;

  typedef enum logic [3:0] {
    OP_BAD, OP_IO_RECONF, OP_REBOOT, OP_EN_HIZ, OP_EN_CLAMP, OP_LEAVE,
    OP_PROG, OP_NOOP, OP_ADDR, OP_ERASE, OP_READ, OP_BG_ON, OP_BG_OFF
  } op_e;
endpackage

// File: rtl/isp_op_decode.sv
module isp_op_decode
  import isp_pkg::*;
(
  input  logic [IR_W-1:0] ir,
  output op_e             op
);
  always_comb begin
    unique case (ir)
      K_IO_RECONF:   op = OP_IO_RECONF;
      K_REBOOT:      op = OP_REBOOT;
      K_EN_TRISTATE: op = OP_EN_HIZ;
      K_EN_HOLD:     op = OP_EN_CLAMP;
      K_LEAVE:       op = OP_LEAVE;
      K_PROG:        op = OP_PROG;
      K_IDLE_OP:     op = OP_NOOP;
      K_ADDR:        op = OP_ADDR;
      K_ERASE:       op = OP_ERASE;
      K_READ:        op = OP_READ;
      K_BG_ON:       op = OP_BG_ON;
      K_BG_OFF:      op = OP_BG_OFF;
      default:       op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/isp_exit_timer.sv
module isp_exit_timer #(
  parameter int EXIT_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic idle,
  output logic done
);
  localparam int CW = (EXIT_CYC > 1) ? $clog2(EXIT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(EXIT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    done  = run && idle && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (start || !run || !idle) cnt_d = '0;
    else if (!done)             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/isp_mode_ctrl.sv
module isp_mode_ctrl
  import isp_pkg::*;
#(
  parameter int EXIT_CYC = 20000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IR_W-1:0] ir_value,
  input  logic            ir_update,
  input  logic            tap_idle,
  input  logic            status_ok,
  output logic [1:0]      mode,
  output logic            exiting,
  output logic            io_hiz,
  output logic            io_clamp,
  output logic            core_freeze,
  output logic [1:0]      dr_sel,
  output logic            prog_stb,
  output logic            erase_stb,
  output logic            read_stb,
  output logic            addr_inc,
  output logic            io_cfg_stb,
  output logic            reconfig_req,
  output logic            bg_intr,
  output logic            bad_op
);
  op_e   op;
  mode_e mode_q, mode_d;
  dr_e   dr_q, dr_d;
  logic  exit_q, exit_d, bad_q, bad_d, bgi_q, bgi_d;
  logic  aok_q, aok_d, rdseen_q, rdseen_d;
  logic  pprog_q, pprog_d, perase_q, perase_d;
  logic  rd_q, rd_d, inc_q, inc_d, cfg_q, cfg_d, rcfg_q, rcfg_d;
  logic  in_isp, active, tmr_done, leave_go;

  isp_op_decode u_dec (.ir(ir_value), .op(op));

  isp_exit_timer #(.EXIT_CYC(EXIT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(leave_go), .run(exit_q),
    .idle(tap_idle), .done(tmr_done)
  );

  assign in_isp   = (mode_q == MD_HIZ) || (mode_q == MD_CLAMP);
  assign active   = (mode_q != MD_USER) && !exit_q;
  assign leave_go = ir_update && (op == OP_LEAVE) && in_isp && !exit_q;

  // next state
  always_comb begin
    mode_d = mode_q;  dr_d = dr_q;  exit_d = exit_q;  bad_d = bad_q;
    bgi_d = bgi_q;    aok_d = aok_q;  rdseen_d = rdseen_q;
    pprog_d = pprog_q && !tap_idle;
    perase_d = perase_q && !tap_idle;
    rd_d = 1'b0;  inc_d = 1'b0;  cfg_d = 1'b0;  rcfg_d = 1'b0;

    if (tmr_done) begin
      mode_d = MD_USER;  exit_d = 1'b0;  dr_d = DR_BYP;
      aok_d = 1'b0;      rdseen_d = 1'b0;
    end

    if (ir_update) begin
      dr_d = DR_BYP;
      unique case (op)
        OP_BAD:       bad_d = 1'b1;
        OP_EN_HIZ:    if (mode_q == MD_USER) mode_d = MD_HIZ;
        OP_EN_CLAMP:  if (mode_q == MD_USER) mode_d = MD_CLAMP;
        OP_BG_ON:     if (mode_q == MD_USER) mode_d = MD_BG;
        OP_LEAVE: if (leave_go) begin
          exit_d = 1'b1;  aok_d = 1'b0;  rdseen_d = 1'b0;
          pprog_d = 1'b0; perase_d = 1'b0;
        end
        OP_BG_OFF: if (mode_q == MD_BG) begin
          mode_d = MD_USER; bgi_d = 1'b0; aok_d = 1'b0; rdseen_d = 1'b0;
          pprog_d = 1'b0;   perase_d = 1'b0;
        end
        OP_REBOOT: if (!in_isp) begin
          rcfg_d = 1'b1;
          if (mode_q == MD_BG) bgi_d = 1'b1;
        end
        OP_IO_RECONF: if (status_ok && !exit_q) cfg_d = 1'b1;
        OP_NOOP:  if (active) dr_d = DR_DFLT;
        OP_ADDR:  if (active) begin
          dr_d = DR_ADDR;  aok_d = 1'b1;  rdseen_d = 1'b0;
        end
        OP_PROG:  if (active) pprog_d = 1'b1;
        OP_ERASE: if (active && aok_q) perase_d = 1'b1;
        OP_READ:  if (active) begin
          rd_d = 1'b1;  inc_d = rdseen_q;  rdseen_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_USER;  dr_q <= DR_BYP;  exit_q <= 1'b0;  bad_q <= 1'b0;
      bgi_q <= 1'b0;      aok_q <= 1'b0;   rdseen_q <= 1'b0;
      pprog_q <= 1'b0;    perase_q <= 1'b0;
      rd_q <= 1'b0;  inc_q <= 1'b0;  cfg_q <= 1'b0;  rcfg_q <= 1'b0;
    end else begin
      mode_q <= mode_d;  dr_q <= dr_d;  exit_q <= exit_d;  bad_q <= bad_d;
      bgi_q <= bgi_d;    aok_q <= aok_d; rdseen_q <= rdseen_d;
      pprog_q <= pprog_d; perase_q <= perase_d;
      rd_q <= rd_d;  inc_q <= inc_d;  cfg_q <= cfg_d;  rcfg_q <= rcfg_d;
    end
  end

  assign mode         = mode_q;
  assign exiting      = exit_q;
  assign io_hiz       = (mode_q == MD_HIZ);
  assign io_clamp     = (mode_q == MD_CLAMP);
  assign core_freeze  = (mode_q == MD_CLAMP);
  assign dr_sel       = dr_q;
  assign prog_stb     = pprog_q && tap_idle && !exit_q;
  assign erase_stb    = perase_q && tap_idle && !exit_q;
  assign read_stb     = rd_q;
  assign addr_inc     = inc_q;
  assign io_cfg_stb   = cfg_q;
  assign reconfig_req = rcfg_q;
  assign bg_intr      = bgi_q;
  assign bad_op       = bad_q;
endmodule

// File: rtl/isp_mode_ctrl_chk.sv
module isp_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tap_idle,
  input logic [1:0] mode,
  input logic       exiting,
  input logic       io_hiz,
  input logic       io_clamp,
  input logic       prog_stb,
  input logic       erase_stb,
  input logic       read_stb,
  input logic       reconfig_req,
  input logic       bad_op
);
  a_r2_hiz_from_user: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_hiz) |-> ($past(mode) == 2'd0));
  a_r3_clamp_from_user: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_clamp) |-> ($past(mode) == 2'd0));
  a_r4_exit_lands_user: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exiting) |-> (mode == 2'd0) && $past(tap_idle));
  a_r5_user_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> !prog_stb && !erase_stb && !read_stb);
  a_r8_prog_single: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> !prog_stb);
  a_r8_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |=> !erase_stb);
  a_r11_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_req |=> !reconfig_req);
  a_r13_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |=> bad_op);
  a_r14_exit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    exiting |-> !prog_stb && !erase_stb && !read_stb);
endmodule

bind isp_mode_ctrl isp_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tap_idle(tap_idle), .mode(mode),
  .exiting(exiting), .io_hiz(io_hiz), .io_clamp(io_clamp),
  .prog_stb(prog_stb), .erase_stb(erase_stb), .read_stb(read_stb),
  .reconfig_req(reconfig_req), .bad_op(bad_op)
);

// File: tb/sim_isp_mode_ctrl.sv
`timescale 1ns/1ps
module sim_isp_mode_ctrl;
  localparam int EXIT_CYC = 8;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n, ir_update, tap_idle, status_ok;
  logic [9:0] ir_value;
  logic [1:0] mode, dr_sel;
  logic exiting, io_hiz, io_clamp, core_freeze, prog_stb, erase_stb, read_stb;
  logic addr_inc, io_cfg_stb, reconfig_req, bg_intr, bad_op;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  isp_mode_ctrl #(.EXIT_CYC(EXIT_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_value(ir_value), .ir_update(ir_update),
    .tap_idle(tap_idle), .status_ok(status_ok), .mode(mode), .exiting(exiting),
    .io_hiz(io_hiz), .io_clamp(io_clamp), .core_freeze(core_freeze),
    .dr_sel(dr_sel), .prog_stb(prog_stb), .erase_stb(erase_stb),
    .read_stb(read_stb), .addr_inc(addr_inc), .io_cfg_stb(io_cfg_stb),
    .reconfig_req(reconfig_req), .bg_intr(bg_intr), .bad_op(bad_op)
  );

  // {opcode, mode, dr_sel, io_hiz, io_clamp, core_freeze, read_stb}
  localparam logic [17:0] VEC [NV] = '{
    {10'h203, 2'd0, 2'd0, 4'b0000},   // R5 address in user
    {10'h205, 2'd0, 2'd0, 4'b0000},   // R5 read in user
    {10'h2CC, 2'd1, 2'd0, 4'b1000},   // R2 enter tri-state
    {10'h210, 2'd1, 2'd1, 4'b1000},   // R6 no-op register
    {10'h203, 2'd1, 2'd2, 4'b1000},   // R6 address register
    {10'h205, 2'd1, 2'd0, 4'b1001},   // R9 first read
    {10'h233, 2'd1, 2'd0, 4'b1000},   // R3 second enable ignored
    {10'h3FF, 2'd1, 2'd0, 4'b1000}    // R13 unsupported opcode
  };
  localparam string VTAG [NV] = '{"R5", "R5", "R2", "R6", "R6", "R9", "R3", "R13"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [9:0] op);
    @(negedge clk);
    ir_value = op;
    ir_update = 1'b1;
    @(negedge clk);
    ir_update = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic leave_isp();
    issue(10'h201);
    tap_idle = 1'b1;
    repeat (EXIT_CYC) @(negedge clk);
    tap_idle = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ir_update = 1'b0;
    tap_idle = 1'b0;
    status_ok = 1'b1;
    ir_value = '0;
    do_reset();
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 outputs", {exiting, io_hiz, io_clamp, core_freeze, dr_sel, prog_stb,
        erase_stb, read_stb, addr_inc, io_cfg_stb, reconfig_req, bg_intr, bad_op}, 0);

    // R5 program in user mode: never fires even in idle
    issue(10'h2F4);
    tap_idle = 1'b1;
    #1 chk("R5 prog in user", prog_stb, 0);
    tap_idle = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][17:8]);
      chk(VTAG[i], {mode, dr_sel, io_hiz, io_clamp, core_freeze, read_stb}, VEC[i][7:0]);
    end
    chk("R13 flag set", bad_op, 1);

    // R8 program waits for idle, single pulse
    issue(10'h2F4);
    @(negedge clk);
    chk("R8 prog not idle", prog_stb, 0);
    tap_idle = 1'b1;
    #1 chk("R8 prog in idle", prog_stb, 1);
    @(negedge clk);
    chk("R8 prog single", prog_stb, 0);
    tap_idle = 1'b0;

    // R7 erase after address was loaded
    issue(10'h2F2);
    tap_idle = 1'b1;
    #1 chk("R7 erase with addr", erase_stb, 1);
    @(negedge clk);
    tap_idle = 1'b0;

    // R9 burst read then explicit address
    issue(10'h205);
    chk("R9 burst read", {read_stb, addr_inc}, 2'b11);
    @(negedge clk);
    chk("R9 read single", read_stb, 0);
    issue(10'h203);
    issue(10'h205);
    chk("R9 read after address", {read_stb, addr_inc}, 2'b10);

    // R4 timed exit with restart
    issue(10'h201);
    chk("R4 exiting", {exiting, io_hiz, mode}, {2'b11, 2'd1});
    issue(10'h205);
    chk("R14 read while exiting", read_stb, 0);
    issue(10'h199);
    chk("R14 mode while exiting", mode, 1);
    tap_idle = 1'b1;
    repeat (3) @(negedge clk);
    tap_idle = 1'b0;
    @(negedge clk);
    tap_idle = 1'b1;
    repeat (EXIT_CYC - 1) @(negedge clk);
    chk("R4 still exiting", {exiting, mode}, {1'b1, 2'd1});
    @(negedge clk);
    chk("R4 back to user", {exiting, io_hiz, mode}, 4'b0000);
    tap_idle = 1'b0;

    // R3 clamp mode, R7 erase without address dropped
    issue(10'h233);
    chk("R3 clamp", {mode, io_hiz, io_clamp, core_freeze}, {2'd2, 3'b011});
    issue(10'h2F2);
    tap_idle = 1'b1;
    #1 chk("R7 erase no addr", erase_stb, 0);
    tap_idle = 1'b0;
    issue(10'h001);
    chk("R11 no request in isp", reconfig_req, 0);
    leave_isp();
    chk("R4 clamp released", {mode, io_clamp, core_freeze}, 4'b0000);

    // R10/R11 background mode
    issue(10'h199);
    chk("R10 background", {mode, io_hiz, io_clamp, core_freeze}, {2'd3, 3'b000});
    issue(10'h001);
    chk("R11 request in bg", {reconfig_req, bg_intr}, 2'b11);
    @(negedge clk);
    chk("R11 request single", {reconfig_req, bg_intr}, 2'b01);
    issue(10'h2CC);
    chk("R11 flag held", {mode, bg_intr}, {2'd3, 1'b1});
    issue(10'h166);
    chk("R10 bg off", {mode, bg_intr}, 3'b000);
    issue(10'h001);
    chk("R11 user request", {reconfig_req, bg_intr}, 2'b10);

    // R12 I/O reconfiguration gated by status
    status_ok = 1'b0;
    issue(10'h00D);
    chk("R12 status low", io_cfg_stb, 0);
    status_ok = 1'b1;
    issue(10'h00D);
    chk("R12 status high", io_cfg_stb, 1);
    @(negedge clk);
    chk("R12 single", io_cfg_stb, 0);

    // R13 sticky until reset
    chk("R13 still set", bad_op, 1);
    do_reset();
    chk("R13 cleared by reset", bad_op, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule